// File: doc/BRIEF.md
# Multi-Stream Sequential Prefetch Buffer

This block sits beside a first-level cache and follows several independent sequential miss streams at once. Each stream owns a small FIFO of prefetched lines, and every entry carries the block address it belongs to. On each access the block compares only the oldest entry of every FIFO with the requested block, in the same cycle as the first-level cache's own probe. A match hands that line to the cache and removes it from its FIFO. The freed slot then lets the stream ask lower memory for one more consecutive block.

When an access misses both the cache and every FIFO head, the block reports a full miss so that the cache fetches the missing block k itself. The block also takes the least recently used stream, empties it and points it at blocks k+1, k+2 and onward. Streams send block requests to lower memory through a valid/ready port. Responses come back in issue order and carry a line and a stream id. A stream that is restarted while some of its old requests are still in flight drops those responses when they arrive.

Top module: `mw_stream_prefetch`

## Requirements
- R1: After reset no stream is active. There are no head hits, and `mreq_valid` stays 0 until the first full miss. The recency order ranks way 0 as most recent and way WAYS-1 as least recent. The request search starts at way 0.
- R2: An access with `acc_valid`=1 and `l1_hit`=0 whose block equals a stream's head tag raises `pf_hit` in the same cycle. In that cycle `pf_way` gives the stream and `pf_line` gives the head line. That entry is removed at the next clock edge.
- R3: An access with `l1_hit`=1, or a cycle with `acc_valid`=0, raises neither `pf_hit` nor `pf_miss`. It pops nothing, restarts nothing and leaves the recency order unchanged. `pf_way` and `pf_line` are 0 in such a cycle.
- R4: An access with `acc_valid`=1 and `l1_hit`=0 that matches no head raises `pf_miss`. The chosen stream is emptied, and its next requests are for blocks k+1, k+2 and so on, with the address wrapping at BLK_W bits.
- R5: On a full miss the stream chosen is the least recently hit or allocated one, and its id appears on `pf_way` in that cycle. A hit or an allocation makes the stream most recent.
- R6: A stream requests only while its held lines, live outstanding requests and stale outstanding requests together number fewer than DEPTH. So it never has more than DEPTH lines and requests combined.
- R7: Responses to requests that a stream issued before its latest restart are discarded. This includes a request accepted in the same cycle as the restart.
- R8: When several heads match the access, the lowest-numbered stream wins, and only that stream pops.
- R9: Requests from eligible streams are granted round-robin. After lower memory accepts a request from way g, the search starts at way g+1 and wraps around. `mreq_blk` and `mreq_id` are 0 while `mreq_valid` is 0.
- R10: Live responses fill the tail of the stream named by `mrsp_id` in arrival order. Each filled line is tagged with the next consecutive block of that stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_blk | input | BLK_W | Block address of the access |
| l1_hit | input | 1 | First-level cache hit for this access |
| pf_hit | output | 1 | A FIFO head supplies the line |
| pf_miss | output | 1 | Full miss; a stream is restarted |
| pf_way | output | log2(WAYS) | Hitting way on a hit, restarted way on a miss, else 0 |
| pf_line | output | LINE_W | Head line on a hit, else 0 |
| mreq_valid | output | 1 | Block request to lower memory |
| mreq_ready | input | 1 | Lower memory accepts the request |
| mreq_blk | output | BLK_W | Requested block address |
| mreq_id | output | log2(WAYS) | Requesting stream |
| mrsp_valid | input | 1 | Response line present |
| mrsp_id | input | log2(WAYS) | Stream the response belongs to |
| mrsp_line | input | LINE_W | Returned line data |

## Verification
The bench tries a single ascending scan, which separates correct refill ordering and tagging from simple head matching. Four interleaved streams followed by a fifth miss show whether replacement follows recency or a fixed rotation. Back-to-back misses under long memory latency make streams restart with requests in flight, which exposes any stale line that slips into a new stream. A repeated miss on the same block builds two streams with equal heads to test hit priority, and a stalled, then random, ready pattern shows both the fill limit and the request rotation.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

   // Outcome of one access cycle as seen by the prefetch buffer
   typedef enum logic [1:0] {
      PROBE_IDLE = 2'd0,
      PROBE_L1   = 2'd1,
      PROBE_HEAD = 2'd2,
      PROBE_MISS = 2'd3
   } probe_e;

endpackage

// File: rtl/pfb_stream.sv
// One sequential stream: line FIFO with tags, request/refill bookkeeping.
module pfb_stream #(
   parameter int BLK_W  = 26,
   parameter int LINE_W = 64,
   parameter int DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_i,
   input  logic [BLK_W-1:0]  flush_blk_i,
   input  logic              pop_i,
   input  logic              fire_i,
   input  logic              rsp_i,
   input  logic [LINE_W-1:0] rsp_line_i,
   output logic              head_ok_o,
   output logic [BLK_W-1:0]  head_tag_o,
   output logic [LINE_W-1:0] head_line_o,
   output logic              want_o,
   output logic [BLK_W-1:0]  next_blk_o
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam int SUM_W = CNT_W + 2;

   logic              active_q;
   logic [PTR_W-1:0]  rd_q, wr_q;
   logic [CNT_W-1:0]  cnt_q, outst_q, stale_q;
   logic [BLK_W-1:0]  nxt_q, ret_q;
   logic [LINE_W-1:0] line_mem [DEPTH];
   logic [BLK_W-1:0]  tag_mem  [DEPTH];

   logic              rsp_stale, rsp_live, push, pop;
   logic [CNT_W-1:0]  outst_after, stale_after;
   logic [SUM_W-1:0]  used;

   assign rsp_stale   = rsp_i && (stale_q != '0);
   assign rsp_live    = rsp_i && (stale_q == '0);
   assign push        = rsp_live && !flush_i;
   assign pop         = pop_i && !flush_i;
   assign outst_after = outst_q + CNT_W'(fire_i) - CNT_W'(rsp_live);
   assign stale_after = stale_q - CNT_W'(rsp_stale);
   assign used        = SUM_W'(cnt_q) + SUM_W'(outst_q) + SUM_W'(stale_q);

   assign want_o      = active_q && (used < SUM_W'(DEPTH));
   assign next_blk_o  = nxt_q;
   assign head_ok_o   = (cnt_q != '0);
   assign head_tag_o  = tag_mem[rd_q];
   assign head_line_o = line_mem[rd_q];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         rd_q     <= '0;
         wr_q     <= '0;
         cnt_q    <= '0;
         outst_q  <= '0;
         stale_q  <= '0;
         nxt_q    <= '0;
         ret_q    <= '0;
      end else if (flush_i) begin
         // Everything still in flight belongs to the old stream now
         active_q <= 1'b1;
         rd_q     <= '0;
         wr_q     <= '0;
         cnt_q    <= '0;
         outst_q  <= '0;
         stale_q  <= stale_after + outst_after;
         nxt_q    <= flush_blk_i + BLK_W'(1);
         ret_q    <= flush_blk_i + BLK_W'(1);
      end else begin
         outst_q  <= outst_after;
         stale_q  <= stale_after;
         cnt_q    <= cnt_q + CNT_W'(push) - CNT_W'(pop);
         if (fire_i) nxt_q <= nxt_q + BLK_W'(1);
         if (push) begin
            wr_q  <= wr_q + PTR_W'(1);
            ret_q <= ret_q + BLK_W'(1);
         end
         if (pop) rd_q <= rd_q + PTR_W'(1);
      end
   end

   // Line storage carries no reset; head is only used while cnt_q != 0
   always_ff @(posedge clk) begin
      if (rst_n && push) begin
         line_mem[wr_q] <= rsp_line_i;
         tag_mem[wr_q]  <= ret_q;
      end
   end

endmodule

// File: rtl/pfb_lru.sv
// Recency ranking by per-way age; age WAYS-1 marks the victim.
module pfb_lru #(
   parameter int WAYS = 4,
   localparam int ID_W = $clog2(WAYS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            touch_i,
   input  logic [ID_W-1:0] touch_id_i,
   output logic [ID_W-1:0] victim_o
);
   logic [ID_W-1:0] age_q [WAYS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < WAYS; i++) age_q[i] <= ID_W'(i);
      end else if (touch_i) begin
         for (int i = 0; i < WAYS; i++) begin
            if (ID_W'(i) == touch_id_i)
               age_q[i] <= '0;
            else if (age_q[i] < age_q[touch_id_i])
               age_q[i] <= age_q[i] + ID_W'(1);
         end
      end
   end

   always_comb begin
      victim_o = '0;
      for (int i = 0; i < WAYS; i++)
         if (age_q[i] == ID_W'(WAYS - 1)) victim_o = ID_W'(i);
   end

endmodule

// File: rtl/pfb_rr_arb.sv
// Round-robin pick among streams that want to issue a request.
module pfb_rr_arb #(
   parameter int WAYS = 4,
   localparam int ID_W = $clog2(WAYS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [WAYS-1:0] req_i,
   input  logic            take_i,
   output logic            gnt_valid_o,
   output logic [ID_W-1:0] gnt_id_o
);
   logic [ID_W-1:0] ptr_q;
   logic [ID_W-1:0] idx;

   always_comb begin
      gnt_valid_o = 1'b0;
      gnt_id_o    = '0;
      idx         = '0;
      // Walk from the far end so the nearest requester is chosen last
      for (int off = WAYS - 1; off >= 0; off--) begin
         idx = ptr_q + ID_W'(off);
         if (req_i[idx]) begin
            gnt_valid_o = 1'b1;
            gnt_id_o    = idx;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                     ptr_q <= '0;
      else if (take_i && gnt_valid_o) ptr_q <= gnt_id_o + ID_W'(1);
   end

endmodule

// File: rtl/mw_stream_prefetch.sv
module mw_stream_prefetch
   import pfb_pkg::*;
#(
   parameter int BLK_W  = 26,
   parameter int LINE_W = 64,
   parameter int WAYS   = 4,
   parameter int DEPTH  = 4,
   localparam int ID_W  = $clog2(WAYS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic [BLK_W-1:0]  acc_blk,
   input  logic              l1_hit,
   output logic              pf_hit,
   output logic              pf_miss,
   output logic [ID_W-1:0]   pf_way,
   output logic [LINE_W-1:0] pf_line,
   output logic              mreq_valid,
   input  logic              mreq_ready,
   output logic [BLK_W-1:0]  mreq_blk,
   output logic [ID_W-1:0]   mreq_id,
   input  logic              mrsp_valid,
   input  logic [ID_W-1:0]   mrsp_id,
   input  logic [LINE_W-1:0] mrsp_line
);
   initial begin
      assert (WAYS >= 2 && (WAYS & (WAYS - 1)) == 0)
         else $error("WAYS must be a power of two, at least 2");
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("DEPTH must be a power of two, at least 2");
      assert (BLK_W >= 2 && LINE_W >= 1)
         else $error("BLK_W and LINE_W out of range");
   end

   logic [WAYS-1:0]   head_ok, want, match, pop, flush, fire, rsp;
   logic [BLK_W-1:0]  head_tag  [WAYS];
   logic [LINE_W-1:0] head_line [WAYS];
   logic [BLK_W-1:0]  next_blk  [WAYS];

   logic              hit_any;
   logic [ID_W-1:0]   hit_id, victim, gnt_id;
   logic              gnt_valid;
   probe_e            probe;

   // Head compare, lowest index wins
   always_comb begin
      hit_any = 1'b0;
      hit_id  = '0;
      for (int i = WAYS - 1; i >= 0; i--) begin
         if (match[i]) begin
            hit_any = 1'b1;
            hit_id  = ID_W'(i);
         end
      end
   end

   always_comb begin
      if (!acc_valid)   probe = PROBE_IDLE;
      else if (l1_hit)  probe = PROBE_L1;
      else if (hit_any) probe = PROBE_HEAD;
      else              probe = PROBE_MISS;
   end

   assign pf_hit  = (probe == PROBE_HEAD);
   assign pf_miss = (probe == PROBE_MISS);
   assign pf_way  = pf_hit ? hit_id : (pf_miss ? victim : '0);
   assign pf_line = pf_hit ? head_line[hit_id] : '0;

   assign mreq_valid = gnt_valid;
   assign mreq_blk   = gnt_valid ? next_blk[gnt_id] : '0;
   assign mreq_id    = gnt_valid ? gnt_id : '0;

   for (genvar g = 0; g < WAYS; g++) begin : g_way
      assign match[g] = head_ok[g] && (head_tag[g] == acc_blk);
      assign pop[g]   = pf_hit  && (hit_id == ID_W'(g));
      assign flush[g] = pf_miss && (victim == ID_W'(g));
      assign fire[g]  = mreq_valid && mreq_ready && (gnt_id == ID_W'(g));
      assign rsp[g]   = mrsp_valid && (mrsp_id == ID_W'(g));

      pfb_stream #(
         .BLK_W (BLK_W),
         .LINE_W(LINE_W),
         .DEPTH (DEPTH)
      ) u_stream (
         .clk        (clk),
         .rst_n      (rst_n),
         .flush_i    (flush[g]),
         .flush_blk_i(acc_blk),
         .pop_i      (pop[g]),
         .fire_i     (fire[g]),
         .rsp_i      (rsp[g]),
         .rsp_line_i (mrsp_line),
         .head_ok_o  (head_ok[g]),
         .head_tag_o (head_tag[g]),
         .head_line_o(head_line[g]),
         .want_o     (want[g]),
         .next_blk_o (next_blk[g])
      );
   end

   pfb_lru #(.WAYS(WAYS)) u_lru (
      .clk       (clk),
      .rst_n     (rst_n),
      .touch_i   (pf_hit || pf_miss),
      .touch_id_i(pf_way),
      .victim_o  (victim)
   );

   pfb_rr_arb #(.WAYS(WAYS)) u_arb (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_i      (want),
      .take_i     (mreq_ready),
      .gnt_valid_o(gnt_valid),
      .gnt_id_o   (gnt_id)
   );

endmodule

// File: rtl/pfb_chk.sv
module pfb_chk #(
   parameter int WAYS  = 4,
   parameter int DEPTH = 4,
   localparam int ID_W = $clog2(WAYS),
   localparam int IF_W = $clog2(DEPTH + 1) + 1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            acc_valid,
   input logic            l1_hit,
   input logic            pf_hit,
   input logic            pf_miss,
   input logic            mreq_valid,
   input logic            mreq_ready,
   input logic [ID_W-1:0] mreq_id,
   input logic            mrsp_valid,
   input logic [ID_W-1:0] mrsp_id
);
   // Requests accepted minus responses returned, per stream id
   logic [IF_W-1:0] infl_q [WAYS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < WAYS; i++) infl_q[i] <= '0;
      end else begin
         for (int i = 0; i < WAYS; i++)
            infl_q[i] <= infl_q[i]
                       + IF_W'(mreq_valid && mreq_ready && mreq_id == ID_W'(i))
                       - IF_W'(mrsp_valid && mrsp_id == ID_W'(i));
      end
   end

   for (genvar g = 0; g < WAYS; g++) begin : g_bound
      a_r6_inflight_bound: assert property (@(posedge clk) disable iff (!rst_n)
         infl_q[g] <= IF_W'(DEPTH));
   end

   a_r3_l1_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && l1_hit) |-> (!pf_hit && !pf_miss));

   a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> (!pf_hit && !pf_miss));

   a_r2_hit_excludes_miss: assert property (@(posedge clk) disable iff (!rst_n)
      pf_hit |-> !pf_miss);

   a_r4_miss_needs_probe: assert property (@(posedge clk) disable iff (!rst_n)
      pf_miss |-> (acc_valid && !l1_hit));

   a_r9_quiet_request_fields: assert property (@(posedge clk) disable iff (!rst_n)
      !mreq_valid |-> (mreq_id == '0));

endmodule

bind mw_stream_prefetch pfb_chk #(
   .WAYS (WAYS),
   .DEPTH(DEPTH)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .acc_valid (acc_valid),
   .l1_hit    (l1_hit),
   .pf_hit    (pf_hit),
   .pf_miss   (pf_miss),
   .mreq_valid(mreq_valid),
   .mreq_ready(mreq_ready),
   .mreq_id   (mreq_id),
   .mrsp_valid(mrsp_valid),
   .mrsp_id   (mrsp_id)
);

// File: tb/mw_stream_prefetch_tb.sv
module mw_stream_prefetch_tb;
   localparam int CLK_PERIOD = 10;
   localparam int W     = 4;
   localparam int D     = 4;
   localparam int BW    = 16;
   localparam int LW    = 64;
   localparam int IDW   = 2;
   localparam int LIMIT = 20000;

   logic          clk, rst_n;
   logic          acc_valid, l1_hit;
   logic [BW-1:0] acc_blk;
   logic          pf_hit, pf_miss;
   logic [IDW-1:0] pf_way;
   logic [LW-1:0] pf_line;
   logic          mreq_valid, mreq_ready;
   logic [BW-1:0] mreq_blk;
   logic [IDW-1:0] mreq_id;
   logic          mrsp_valid;
   logic [IDW-1:0] mrsp_id;
   logic [LW-1:0] mrsp_line;

   mw_stream_prefetch #(.BLK_W(BW), .LINE_W(LW), .WAYS(W), .DEPTH(D)) u_dut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_blk(acc_blk),
      .l1_hit(l1_hit), .pf_hit(pf_hit), .pf_miss(pf_miss), .pf_way(pf_way),
      .pf_line(pf_line), .mreq_valid(mreq_valid), .mreq_ready(mreq_ready),
      .mreq_blk(mreq_blk), .mreq_id(mreq_id), .mrsp_valid(mrsp_valid),
      .mrsp_id(mrsp_id), .mrsp_line(mrsp_line)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   // Behavioural reference state
   logic [BW-1:0] mt [W][D];
   logic [LW-1:0] ml [W][D];
   int            mn [W];
   int            mout [W];
   int            mdrop [W];
   bit            mact [W];
   logic [BW-1:0] mnext [W];
   logic [BW-1:0] mret [W];
   int            order [$];
   int            rr;

   typedef struct {
      logic [BW-1:0] blk;
      int            id;
      int            due;
   } pend_t;
   pend_t pend [$];
   int    last_due;

   int    cyc;
   int    checks, errors;
   int    ready_mode, lat_base, lat_span;
   string phase;

   function automatic logic [LW-1:0] line_of(input logic [BW-1:0] b);
      return {16'hC0DE, ~b, 16'h5A5A, b};
   endfunction

   task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s got %0h exp %0h", phase, what, act, exp);
      end
   endtask

   task automatic touch(input int w);
      for (int i = 0; i < order.size(); i++) begin
         if (order[i] == w) begin
            order.delete(i);
            break;
         end
      end
      order.push_front(w);
   endtask

   task automatic summary_and_end();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc = cyc + 1;
      if (cyc > LIMIT) begin
         errors++;
         $display("FAIL watchdog expired after %0d cycles", cyc);
         summary_and_end();
      end
   end

   // One cycle: drive, compare against the model, advance the model
   task automatic step(input bit av, input logic [BW-1:0] b, input bit l1);
      int hw, g, v;
      bit e_hit, e_miss, e_mv, probe, fired;
      int e_way;
      logic [LW-1:0] e_line;
      logic [BW-1:0] e_mblk;

      acc_valid = av;
      acc_blk   = b;
      l1_hit    = l1;
      case (ready_mode)
         0:       mreq_ready = 1'b1;
         1:       mreq_ready = 1'b0;
         default: mreq_ready = 1'($urandom % 2);
      endcase
      if (pend.size() > 0 && pend[0].due <= cyc) begin
         mrsp_valid = 1'b1;
         mrsp_id    = IDW'(pend[0].id);
         mrsp_line  = line_of(pend[0].blk);
      end else begin
         mrsp_valid = 1'b0;
         mrsp_id    = '0;
         mrsp_line  = '0;
      end
      #1;

      probe = av && !l1;
      hw = -1;
      for (int i = 0; i < W; i++) begin
         if (probe && mn[i] > 0 && mt[i][0] == b) begin
            hw = i;
            break;
         end
      end
      e_hit  = (hw >= 0);
      e_miss = probe && !e_hit;
      e_way  = e_hit ? hw : (e_miss ? order[order.size() - 1] : 0);
      e_line = e_hit ? ml[hw][0] : '0;

      g = -1;
      for (int off = 0; off < W; off++) begin
         int idx;
         idx = (rr + off) % W;
         if (mact[idx] && (mn[idx] + mout[idx] + mdrop[idx] < D)) begin
            g = idx;
            break;
         end
      end
      e_mv   = (g >= 0);
      e_mblk = e_mv ? mnext[g] : '0;

      check("pf_hit",     64'(pf_hit),     64'(e_hit));
      check("pf_miss",    64'(pf_miss),    64'(e_miss));
      check("pf_way",     64'(pf_way),     64'(e_way));
      check("pf_line",    pf_line,         e_line);
      check("mreq_valid", 64'(mreq_valid), 64'(e_mv));
      check("mreq_blk",   64'(mreq_blk),   64'(e_mblk));
      check("mreq_id",    64'(mreq_id),    64'(e_mv ? g : 0));

      // responses
      if (mrsp_valid) begin
         int id;
         id = pend[0].id;
         void'(pend.pop_front());
         if (mdrop[id] > 0) begin
            mdrop[id]--;
         end else begin
            if (mn[id] < D) begin
               mt[id][mn[id]] = mret[id];
               ml[id][mn[id]] = mrsp_line;
               mn[id]++;
            end
            mret[id]++;
            mout[id]--;
         end
      end
      // request acceptance
      fired = e_mv && mreq_ready;
      if (fired) begin
         int due;
         mout[g]++;
         mnext[g]++;
         rr  = (g + 1) % W;
         due = cyc + 1 + lat_base + ((lat_span > 0) ? int'($urandom % lat_span) : 0);
         if (due < last_due) due = last_due;
         last_due = due;
         pend.push_back('{blk: e_mblk, id: g, due: due});
      end
      // head pop
      if (e_hit) begin
         for (int j = 0; j < D - 1; j++) begin
            mt[hw][j] = mt[hw][j + 1];
            ml[hw][j] = ml[hw][j + 1];
         end
         mn[hw]--;
         touch(hw);
      end
      // stream restart
      if (e_miss) begin
         v = e_way;
         mdrop[v] += mout[v];
         mout[v]  = 0;
         mn[v]    = 0;
         mact[v]  = 1'b1;
         mnext[v] = b + BW'(1);
         mret[v]  = b + BW'(1);
         touch(v);
      end
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) step(1'b0, BW'(16'h0BAD), 1'b0);
   endtask

   initial begin
      checks = 0; errors = 0; cyc = 0; rr = 0; last_due = 0;
      ready_mode = 0; lat_base = 2; lat_span = 0;
      phase = "R1";
      for (int i = 0; i < W; i++) begin
         mn[i] = 0; mout[i] = 0; mdrop[i] = 0; mact[i] = 1'b0;
         mnext[i] = '0; mret[i] = '0;
         order.push_back(i);
      end
      rst_n = 1'b0; acc_valid = 1'b0; acc_blk = '0; l1_hit = 1'b0;
      mreq_ready = 1'b0; mrsp_valid = 1'b0; mrsp_id = '0; mrsp_line = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: quiet after reset, nothing requested
      idle(3);
      step(1'b1, BW'(16'd50), 1'b1);

      // R4: first full miss restarts way W-1 on 101, 102, ...
      phase = "R4";
      step(1'b1, BW'(16'd100), 1'b0);
      idle(8);
      // R2: consecutive head hits
      phase = "R2";
      for (int k = 1; k <= 6; k++) begin
         step(1'b1, BW'(100 + k), 1'b0);
         idle(3);
      end

      // R5: four interleaved streams then a fifth miss takes the oldest
      phase = "R5";
      step(1'b1, BW'(16'd1000), 1'b0);
      step(1'b1, BW'(16'd2000), 1'b0);
      step(1'b1, BW'(16'd3000), 1'b0);
      step(1'b1, BW'(16'd4000), 1'b0);
      idle(12);
      step(1'b1, BW'(16'd1001), 1'b0);
      step(1'b1, BW'(16'd2001), 1'b0);
      step(1'b1, BW'(16'd5000), 1'b0);
      idle(8);

      // R3: cache hits and idle cycles leave heads intact
      phase = "R3";
      for (int k = 0; k < 3; k++) step(1'b1, BW'(16'd2002), 1'b1);
      step(1'b0, BW'(16'd2002), 1'b0);
      step(1'b1, BW'(16'd2002), 1'b0);
      step(1'b1, BW'(16'd9999), 1'b1);

      // R6: stalled memory, then every stream fills to its limit
      phase = "R6";
      ready_mode = 1;
      step(1'b1, BW'(16'd7000), 1'b0);
      idle(6);
      ready_mode = 0; lat_base = 1;
      idle(30);

      // R9: rotation under random acceptance
      phase = "R9";
      ready_mode = 2;
      step(1'b1, BW'(16'd8000), 1'b0);
      step(1'b1, BW'(16'd9000), 1'b0);
      step(1'b1, BW'(16'd10000), 1'b0);
      idle(25);
      step(1'b1, BW'(16'd8001), 1'b0);
      step(1'b1, BW'(16'd9001), 1'b0);
      idle(10);

      // R7: repeated restarts with long latency leave stale responses in flight
      phase = "R7";
      ready_mode = 0; lat_base = 12; lat_span = 4;
      for (int k = 0; k < 8; k++) step(1'b1, BW'(12000 + 1000 * k), 1'b0);
      idle(70);
      for (int k = 4; k < 8; k++) step(1'b1, BW'(12001 + 1000 * k), 1'b0);
      idle(10);

      // R8: two streams with the same head, lowest index first
      phase = "R8";
      lat_base = 1; lat_span = 0;
      step(1'b1, BW'(16'd500), 1'b0);
      idle(6);
      step(1'b1, BW'(16'd500), 1'b0);
      idle(8);
      step(1'b1, BW'(16'd501), 1'b0);
      step(1'b1, BW'(16'd501), 1'b0);
      step(1'b1, BW'(16'd501), 1'b0);
      idle(4);

      // R10: long scan with random acceptance and latency, ending at wrap
      phase = "R10";
      ready_mode = 2; lat_base = 1; lat_span = 5;
      step(1'b1, BW'(16'hFFF0), 1'b0);
      for (int k = 1; k <= 40; k++) begin
         step(1'b1, BW'(16'hFFF0 + k), 1'b0);
         idle(5);
      end
      idle(20);

      summary_and_end();
   end

endmodule